// File: doc/BRIEF.md
# Bidirectional Strobed Bus Port

This block is one 8-bit peripheral port that carries traffic both ways over a single shared data bus, with a handshake for each direction. Data from the peripheral is captured into an input latch while the peripheral holds its strobe low. The CPU collects that data with a read. Data from the CPU goes into a separate output latch. It is put onto the shared bus only while the peripheral holds its acknowledge low. At all other times the bus driver is released.

Two flags report the state of the latches. The input-full flag is active high. The output-full flag is active low. One interrupt line combines the service requests of both directions. Each direction has its own enable. Those enables are written with single-bit set/clear commands that address the control lines by position. The five control lines can be read back as one bundle in port-C order. Register decode is not part of this block: the read and write strobes are already qualified for this port. All strobe inputs are assumed to be synchronous to the clock.

Top module: `bidir_strobe_port`

## Requirements
- R1: After a synchronous reset, `ibf` is 0, `obf_n` is 1, both interrupt enables are 0, `intr` is 0, and `pa_oe` is 0 while `ack_n` is high.
- R2: In every clock edge where `stb_n` is low, the input latch captures `pa_in` and `ibf` becomes 1. While `stb_n` is high, `cpu_rdata` keeps the captured value whatever `pa_in` does.
- R3: `ibf` returns to 0 at the edge after `cpu_rd_n` goes from low to high. If `stb_n` is low at that edge, `ibf` stays 1.
- R4: At each edge where `cpu_wr_n` is low, the output latch captures `cpu_wdata` and shows it on `pa_out`. `obf_n` goes to 0 at the edge after `cpu_wr_n` returns high.
- R5: An edge with `ack_n` low sets `obf_n` to 1. If the same edge ends a write (the low-to-high change of `cpu_wr_n`), the write wins and `obf_n` goes to 0.
- R6: `pa_oe` is 1 exactly while `ack_n` is low. It follows `ack_n` within the same cycle.
- R7: A set/clear command writes `bsr_val` into `inte_in` when `bsr_sel` is 4, and into `inte_out` when `bsr_sel` is 6. Any other `bsr_sel` value leaves both enables unchanged.
- R8: `intr` = (`stb_n` & `ibf` & `inte_in`) | (`ack_n` & `obf_n` & `inte_out`).
- R9: `ctl_view` bit 0 is `intr`, bit 1 is `stb_n`, bit 2 is `ibf`, bit 3 is `ack_n` and bit 4 is `obf_n`. These are the control lines at positions 3 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_rd_n | input | 1 | CPU read strobe for this port, active low |
| cpu_wr_n | input | 1 | CPU write strobe for this port, active low |
| cpu_wdata | input | 8 | Data the CPU writes |
| cpu_rdata | output | 8 | Input latch contents |
| bsr_en | input | 1 | Single-bit set/clear command valid |
| bsr_sel | input | 3 | Control-line position addressed by the command |
| bsr_val | input | 1 | Value written by the command |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pa_in | input | 8 | Shared bus as seen from the pins |
| pa_out | output | 8 | Output latch value for the bus driver |
| pa_oe | output | 1 | Bus driver enable |
| ibf | output | 1 | Input latch full |
| obf_n | output | 1 | Output latch full, active low |
| intr | output | 1 | Combined interrupt request |
| inte_in | output | 1 | Input-side interrupt enable |
| inte_out | output | 1 | Output-side interrupt enable |
| ctl_view | output | 5 | Control lines at positions 3 to 7 |

## Verification
The bench builds the block with its defaults: an 8-bit bus, with enable positions 4 and 6. At these values the command encodings and the `ctl_view` bit order in the requirements are the ones a system would use. The default positions also make both collision cases reachable: a read ending during a strobe, and a write ending during an acknowledge. So are commands aimed at positions that must be ignored, and each term of the interrupt on its own.

// File: rtl/bsp_pkg.sv
// Shared types and helpers for the bidirectional strobed bus port.
// Assumes all strobes are already synchronous to the block clock.
package bsp_pkg;

    // Number of control lines the port borrows (positions 3 to 7).
    localparam int CTL_LINES = 5;

    // Single-bit set/clear command aimed at a control-line position.
    typedef struct packed {
        logic       en;
        logic [2:0] sel;
        logic       val;
    } bsr_cmd_t;

    // True when an active-low strobe ends: low last edge, high now.
    function automatic logic strobe_end(input logic prev_n, input logic cur_n);
        return !prev_n && cur_n;
    endfunction

endpackage

// File: rtl/bsp_rx.sv
// Inbound side: the input latch and the input-full flag.
// The latch loads at every edge while the strobe is low.
// The flag clears when a CPU read ends; a strobe at that edge wins.
module bsp_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_n,
    input  logic         rd_n,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] data_q,
    output logic         ibf
);
    import bsp_pkg::*;

    logic rd_q;
    logic rd_end;

    // Previous read strobe level, used to find the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b1;
        else        rd_q <= rd_n;
    end

    assign rd_end = strobe_end(rd_q, rd_n);

    // Input latch: follows the bus while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (!stb_n) data_q <= pa_in;
    end

    // Input-full flag: set by the strobe, cleared by the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      ibf <= 1'b0;
        else if (!stb_n) ibf <= 1'b1;
        else if (rd_end) ibf <= 1'b0;
    end

    // A strobe loads the bus value and marks the latch full (R2).
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_n |=> (ibf && data_q == $past(pa_in)));

    // With the strobe high the latch holds (R2).
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stb_n |=> $stable(data_q));

    // The end of a read with no strobe empties the latch (R3).
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_q && rd_n && stb_n) |=> !ibf);

endmodule

// File: rtl/bsp_tx.sv
// Outbound side: the output latch, the active-low output-full flag
// and the bus driver enable. The driver is on only while the
// acknowledge is low. When a write ends in the same edge as an
// acknowledge, the write wins.
module bsp_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_n,
    input  logic [W-1:0] wdata,
    input  logic         ack_n,
    output logic [W-1:0] data_q,
    output logic         obf_n,
    output logic         oe
);
    import bsp_pkg::*;

    logic wr_q;
    logic wr_end;

    // Previous write strobe level, used to find the end of a write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    assign wr_end = strobe_end(wr_q, wr_n);

    // Output latch: loads CPU data while the write strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n)     data_q <= '0;
        else if (!wr_n) data_q <= wdata;
    end

    // Output-full flag: asserted by the end of a write, released by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      obf_n <= 1'b1;
        else if (wr_end) obf_n <= 1'b0;
        else if (!ack_n) obf_n <= 1'b1;
    end

    // Bus driver enable: on only while the peripheral acknowledges.
    assign oe = !ack_n;

    // Write data reaches the latch one edge later (R4).
    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> data_q == $past(wdata));

    // The end of a write marks the latch full, even under acknowledge (R4, R5).
    assert_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_q && wr_n) |=> !obf_n);

    // Acknowledge with no write ending releases the flag (R5).
    assert_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !(!wr_q && wr_n)) |=> obf_n);

endmodule

// File: rtl/bsp_irq.sv
// Interrupt enables and the combined interrupt request.
// Each enable is written by a set/clear command at its own
// control-line position. The request merges the inbound and the
// outbound service conditions.
module bsp_irq
    import bsp_pkg::*;
#(
    parameter int IN_BIT  = 4,
    parameter int OUT_BIT = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  bsr_cmd_t cmd,
    input  logic     stb_n,
    input  logic     ibf,
    input  logic     ack_n,
    input  logic     obf_n,
    output logic     inte_in,
    output logic     inte_out,
    output logic     intr
);
    localparam logic [2:0] IN_SEL  = 3'(IN_BIT);
    localparam logic [2:0] OUT_SEL = 3'(OUT_BIT);

    logic in_req;
    logic out_req;

    // Enable bits: updated only by commands aimed at their positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inte_in  <= 1'b0;
            inte_out <= 1'b0;
        end else if (cmd.en) begin
            if (cmd.sel == IN_SEL)  inte_in  <= cmd.val;
            if (cmd.sel == OUT_SEL) inte_out <= cmd.val;
        end
    end

    // Service conditions for each direction, merged on one line.
    always_comb begin
        in_req  = stb_n && ibf && inte_in;
        out_req = ack_n && obf_n && inte_out;
        intr    = in_req || out_req;
    end

    // A command at the input position writes the input enable (R7).
    assert_in_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.en && cmd.sel == IN_SEL) |=> inte_in == $past(cmd.val));

    // A command at the output position writes the output enable (R7).
    assert_out_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.en && cmd.sel == OUT_SEL) |=> inte_out == $past(cmd.val));

    // Commands at other positions leave both enables alone (R7).
    assert_other_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd.en && (cmd.sel == IN_SEL || cmd.sel == OUT_SEL))
            |=> ($stable(inte_in) && $stable(inte_out)));

    // With both enables clear no request is raised (R8).
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inte_in && !inte_out) |-> !intr);

endmodule

// File: rtl/bidir_strobe_port.sv
// Bidirectional strobed bus port: one shared bus with separate
// inbound and outbound latches, two handshakes and a combined
// interrupt. It assumes the CPU strobes are already decoded for
// this port and that every input is synchronous to clk.
module bidir_strobe_port #(
    parameter int W       = 8,
    parameter int IN_BIT  = 4,
    parameter int OUT_BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_rd_n,
    input  logic         cpu_wr_n,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    input  logic         bsr_en,
    input  logic [2:0]   bsr_sel,
    input  logic         bsr_val,
    input  logic         stb_n,
    input  logic         ack_n,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic         pa_oe,
    output logic         ibf,
    output logic         obf_n,
    output logic         intr,
    output logic         inte_in,
    output logic         inte_out,
    output logic [4:0]   ctl_view
);
    import bsp_pkg::*;

    bsr_cmd_t cmd;
    logic [CTL_LINES-1:0] ctl_bus;

    // Bundle the set/clear command fields.
    assign cmd = '{en: bsr_en, sel: bsr_sel, val: bsr_val};

    bsp_rx #(.W(W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_n  (stb_n),
        .rd_n   (cpu_rd_n),
        .pa_in  (pa_in),
        .data_q (cpu_rdata),
        .ibf    (ibf)
    );

    bsp_tx #(.W(W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (cpu_wr_n),
        .wdata  (cpu_wdata),
        .ack_n  (ack_n),
        .data_q (pa_out),
        .obf_n  (obf_n),
        .oe     (pa_oe)
    );

    bsp_irq #(.IN_BIT(IN_BIT), .OUT_BIT(OUT_BIT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .stb_n    (stb_n),
        .ibf      (ibf),
        .ack_n    (ack_n),
        .obf_n    (obf_n),
        .inte_in  (inte_in),
        .inte_out (inte_out),
        .intr     (intr)
    );

    // Control lines in position order 3 to 7.
    assign ctl_bus  = {obf_n, ack_n, ibf, stb_n, intr};
    assign ctl_view = ctl_bus;

    // The output flag only falls after a write strobe (R4).
    assert_obf_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(obf_n) |-> $past(cpu_wr_n));

    // The input flag only rises after a strobe (R2).
    assert_ibf_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(!stb_n));

endmodule

// File: tb/bidir_strobe_port_bench.sv
module bidir_strobe_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_rd_n = 1'b1, cpu_wr_n = 1'b1;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic       bsr_en = 1'b0, bsr_val = 1'b0;
    logic [2:0] bsr_sel = '0;
    logic       stb_n = 1'b1, ack_n = 1'b1;
    logic [7:0] pa_in = '0, pa_out;
    logic       pa_oe, ibf, obf_n, intr, inte_in, inte_out;
    logic [4:0] ctl_view;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bidir_strobe_port u_bidir_strobe_port (
        .clk(clk), .rst_n(rst_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bsr_en(bsr_en),
        .bsr_sel(bsr_sel), .bsr_val(bsr_val), .stb_n(stb_n), .ack_n(ack_n),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .ibf(ibf),
        .obf_n(obf_n), .intr(intr), .inte_in(inte_in), .inte_out(inte_out),
        .ctl_view(ctl_view)
    );

    task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cmd(logic [2:0] sel, logic val);
        bsr_en = 1'b1; bsr_sel = sel; bsr_val = val;
        step();
        bsr_en = 1'b0;
    endtask

    task automatic t_reset();
        check_eq("R1 ibf", ibf, 0);
        check_eq("R1 obf_n", obf_n, 1);
        check_eq("R1 inte", {inte_in, inte_out}, 0);
        check_eq("R1 intr", intr, 0);
        check_eq("R1 pa_oe", pa_oe, 0);
    endtask

    task automatic t_strobe_read();
        pa_in = 8'hA5; stb_n = 1'b0; step();
        check_eq("R2 ibf set", ibf, 1);
        check_eq("R2 latch", cpu_rdata, 8'hA5);
        stb_n = 1'b1; pa_in = 8'h3C; step();
        check_eq("R2 hold", cpu_rdata, 8'hA5);
        cpu_rd_n = 1'b0; step();
        check_eq("R3 ibf during read", ibf, 1);
        cpu_rd_n = 1'b1; step();
        check_eq("R3 ibf cleared", ibf, 0);
    endtask

    task automatic t_read_vs_strobe();
        cpu_rd_n = 1'b0; step();
        cpu_rd_n = 1'b1; stb_n = 1'b0; pa_in = 8'h22; step();
        check_eq("R3 strobe wins", ibf, 1);
        check_eq("R2 new data", cpu_rdata, 8'h22);
        stb_n = 1'b1; cpu_rd_n = 1'b0; step();
        cpu_rd_n = 1'b1; step();
        check_eq("R3 cleared after", ibf, 0);
    endtask

    task automatic t_write_ack();
        cpu_wr_n = 1'b0; cpu_wdata = 8'h5A; step();
        check_eq("R4 obf_n while writing", obf_n, 1);
        check_eq("R4 pa_out", pa_out, 8'h5A);
        cpu_wr_n = 1'b1; cpu_wdata = 8'hFF; step();
        check_eq("R4 obf_n full", obf_n, 0);
        check_eq("R4 latch kept", pa_out, 8'h5A);
        check_eq("R6 oe off", pa_oe, 0);
        ack_n = 1'b0; #1;
        check_eq("R6 oe on", pa_oe, 1);
        step();
        check_eq("R5 ack releases", obf_n, 1);
        ack_n = 1'b1; #1;
        check_eq("R6 oe off again", pa_oe, 0);
    endtask

    task automatic t_write_vs_ack();
        ack_n = 1'b0; cpu_wr_n = 1'b0; cpu_wdata = 8'hC3; step();
        cpu_wr_n = 1'b1; step();
        check_eq("R5 write wins", obf_n, 0);
        check_eq("R4 pa_out C3", pa_out, 8'hC3);
        ack_n = 1'b1; step();
        check_eq("R5 stays full", obf_n, 0);
        ack_n = 1'b0; step();
        ack_n = 1'b1; step();
        check_eq("R5 released", obf_n, 1);
    endtask

    task automatic t_irq();
        cmd(3'd5, 1'b1);
        check_eq("R7 sel5 ignored", {inte_in, inte_out}, 0);
        cmd(3'd7, 1'b1);
        check_eq("R7 sel7 ignored", {inte_in, inte_out}, 0);
        cmd(3'd4, 1'b1);
        check_eq("R7 inte_in set", {inte_in, inte_out}, 2'b10);
        check_eq("R8 empty no intr", intr, 0);
        stb_n = 1'b0; pa_in = 8'h77; step();
        check_eq("R8 strobe low masks", intr, 0);
        check_eq("R9 view strobing", ctl_view, 5'b11100);
        stb_n = 1'b1; #1;
        check_eq("R8 input request", intr, 1);
        check_eq("R9 view request", ctl_view, 5'b11111);
        step();
        cmd(3'd4, 1'b0);
        check_eq("R8 input disabled", intr, 0);
        cpu_rd_n = 1'b0; step();
        cpu_rd_n = 1'b1; step();
        cmd(3'd6, 1'b1);
        check_eq("R7 inte_out set", {inte_in, inte_out}, 2'b01);
        check_eq("R8 output ready", intr, 1);
        cpu_wr_n = 1'b0; cpu_wdata = 8'h0F; step();
        cpu_wr_n = 1'b1; step();
        check_eq("R8 full no intr", intr, 0);
        check_eq("R9 view full", ctl_view, 5'b01010);
        ack_n = 1'b0; step();
        check_eq("R8 ack low masks", intr, 0);
        ack_n = 1'b1; #1;
        check_eq("R8 output request", intr, 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_strobe_read();
        t_read_vs_strobe();
        t_write_ack();
        t_write_vs_ack();
        t_irq();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected done");
            finish_run();
        end
    end
endmodule